// File: doc/BRIEF.md
# Stereo PCM/DSD Three-Pin Audio Serializer

This block turns a stream of stereo sample pairs into serial audio on three pins: a bit clock, a frame pin and a data pin. It runs from the audio master clock. Bit-clock rates are fixed fractions of the master clock, set by parameters. In PCM mode a frame is 64 bit clocks, split into a 32-slot left half and a 32-slot right half. The sample can be placed in three ways: delayed by one bit after the frame edge, aligned to the frame edge, or aligned to the end of the half-frame. The word width is 16, 24 or 32 bits.

In DSD mode the same pins take new roles. The bit-clock pin becomes the DSD clock, the frame pin carries the left one-bit stream and the data pin carries the right one-bit stream. Each accepted pair then supplies 32 DSD bits per channel. A select input picks the base DSD rate or the doubled rate.

Samples enter through a valid/ready handshake into a single holding register. Mode, format, width and rate inputs are sampled only at frame boundaries. After any change, the data output is held low for one full frame.

Top module: `audio_serial_tx`

## Requirements
- R1: While reset is asserted, `bclk_o`, `frm_o` and `dat_o` are low and `smp_ready_o` is high.
- R2: `dat_o` changes only in the master-clock cycle where `bclk_o` falls, so it is stable at every rising edge. Every PCM word is sent MSB first.
- R3: In PCM mode the bit clock period is 2*PCM_HALF master clocks. A frame is 64 bit clocks. `frm_o` is low for the 32 left slots, then high for the 32 right slots, and changes only on a falling bit-clock edge.
- R4: With `fmt_sel_i`=00 (default delayed framing), the MSB of each channel is sent in the second slot of its half. Slot 0 of each half carries the last bit of the preceding half.
- R5: With `fmt_sel_i`=01 (left-aligned), the MSB is sent in slot 0 of its half, and the slots after the LSB are zero.
- R6: With `fmt_sel_i`=10 (right-aligned), the half begins with zero padding, and the LSB is sent in slot 31, the last bit clock of the half.
- R7: `fmt_sel_i`=11 gives exactly the same output as 00.
- R8: `width_sel_i` 00, 01, 10/11 select 16, 24 and 32-bit words. A sample sits in the low bits of its 32-bit input, and bits above the width are ignored.
- R9: A pair is accepted when `smp_valid_i` and `smp_ready_o` are both high. After acceptance `smp_ready_o` is low until the next frame boundary, where the pair is loaded for that frame and ready returns high. A frame with no pending pair sends zeros.
- R10: With `dsd_mode_i`=1, `bclk_o` has a period of 2*DSD64_HALF master clocks (`dsd_fast_i`=0) or 2*DSD128_HALF (`dsd_fast_i`=1). A frame is 32 DSD clocks. `frm_o` sends left bits 31..0 and `dat_o` sends right bits 31..0, one per clock, changing on the falling edge.
- R11: Changes to the mode, format, width and rate inputs take effect only at a frame boundary. In the first frame after a change, `dat_o` is held low (in DSD mode `frm_o` is held low too).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Audio master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Sample pair offered |
| smp_ready_o | output | 1 | Holding register empty |
| smp_left_i | input | 32 | Left sample, right-aligned (or 32 DSD bits) |
| smp_right_i | input | 32 | Right sample, right-aligned (or 32 DSD bits) |
| dsd_mode_i | input | 1 | 1 selects DSD mode |
| dsd_fast_i | input | 1 | 1 selects the doubled DSD rate |
| fmt_sel_i | input | 2 | PCM framing: 00 delayed, 01 left-aligned, 10 right-aligned |
| width_sel_i | input | 2 | Word width: 00=16, 01=24, else 32 |
| bclk_o | output | 1 | Bit clock / DSD clock |
| frm_o | output | 1 | Frame pin / left DSD stream |
| dat_o | output | 1 | Serial data / right DSD stream |

## Verification
All three pins are registered and move together in the master-clock cycle where the bit clock falls. The bench therefore reads them on rising edges of `bclk_o`, half a bit period away from any change.

An accepted pair is not sent at once. It appears in the frame that starts at the next frame boundary. A setting change shows up one boundary later, and the frame after that boundary is silent. The bench follows this timing exactly: it pushes a pair just after a falling edge of `frm_o`, then captures the frame that starts at the following falling edge. After a configuration change it skips one whole frame before capturing.

In DSD mode there is no frame marker, so the bench finds the start of a frame by waiting for the first 1 on the left stream after the silent frame.

// File: rtl/audser_pkg.sv
package audser_pkg;

  localparam int SLOT_W = 32;
  localparam int POS_W  = $clog2(2 * SLOT_W);

  typedef enum logic [1:0] {
    FMT_DELAY = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2
  } fmt_e;

  typedef struct packed {
    logic       dsd;
    logic       dsd_fast;
    fmt_e       fmt;
    logic [1:0] wsel;
  } cfg_t;

  function automatic fmt_e fmt_decode(input logic [1:0] sel);
    case (sel)
      2'b01:   return FMT_LEFT;
      2'b10:   return FMT_RIGHT;
      default: return FMT_DELAY;
    endcase
  endfunction

  function automatic logic [5:0] width_bits(input logic [1:0] wsel);
    case (wsel)
      2'b00:   return 6'd16;
      2'b01:   return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/audser_clkgen.sv
module audser_clkgen
  import audser_pkg::*;
#(
  parameter int PCM_HALF    = 2,
  parameter int DSD64_HALF  = 4,
  parameter int DSD128_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  cfg_t cfg_i,
  output logic bclk_o,
  output logic fall_o
);

  localparam int MAX_A    = (PCM_HALF > DSD64_HALF) ? PCM_HALF : DSD64_HALF;
  localparam int MAX_HALF = (MAX_A > DSD128_HALF) ? MAX_A : DSD128_HALF;
  localparam int CW       = $clog2(MAX_HALF + 1);

  logic [CW-1:0] div_q, div_d, half_m1;
  logic          bclk_q, bclk_d, tick;
  int unsigned   half;

  always_comb begin
    if (cfg_i.dsd) half = cfg_i.dsd_fast ? DSD128_HALF : DSD64_HALF;
    else           half = PCM_HALF;
    half_m1 = CW'(half - 1);
    tick    = (div_q >= half_m1);
    div_d   = tick ? '0 : div_q + 1'b1;
    bclk_d  = tick ? ~bclk_q : bclk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      bclk_q <= bclk_d;
    end
  end

  assign bclk_o = bclk_q;
  assign fall_o = tick & bclk_q;

endmodule

// File: rtl/audser_bitsel.sv
module audser_bitsel
  import audser_pkg::*;
(
  input  cfg_t              cfg_i,
  input  logic [SLOT_W-1:0] left_i,
  input  logic [SLOT_W-1:0] right_i,
  input  logic [POS_W-1:0]  pos_i,
  output logic              lj_o,
  output logic              rj_o,
  output logic              dsd_l_o,
  output logic              dsd_r_o
);

  logic [4:0]        slot;
  logic [5:0]        wbits;
  logic [4:0]        lj_idx;
  logic [SLOT_W-1:0] word;

  always_comb begin
    slot   = pos_i[4:0];
    word   = pos_i[5] ? right_i : left_i;
    wbits  = width_bits(cfg_i.wsel);
    lj_idx = 5'(wbits - 6'd1 - {1'b0, slot});
    lj_o   = ({1'b0, slot} < wbits) ? word[lj_idx] : 1'b0;
    rj_o   = ({1'b0, slot} >= (6'd32 - wbits)) ? word[~slot] : 1'b0;
    dsd_l_o = left_i[~slot];
    dsd_r_o = right_i[~slot];
  end

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import audser_pkg::*;
#(
  parameter int PCM_HALF    = 2,
  parameter int DSD64_HALF  = 4,
  parameter int DSD128_HALF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  output logic              smp_ready_o,
  input  logic [SLOT_W-1:0] smp_left_i,
  input  logic [SLOT_W-1:0] smp_right_i,
  input  logic              dsd_mode_i,
  input  logic              dsd_fast_i,
  input  logic [1:0]        fmt_sel_i,
  input  logic [1:0]        width_sel_i,
  output logic              bclk_o,
  output logic              frm_o,
  output logic              dat_o
);

  localparam logic [POS_W-1:0] PCM_LAST = POS_W'(2 * SLOT_W - 1);
  localparam logic [POS_W-1:0] DSD_LAST = POS_W'(SLOT_W - 1);

  cfg_t              cfg_q, cfg_d, cfg_in;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic              mute_q, mute_d, full_q, full_d;
  logic [SLOT_W-1:0] hl_q, hl_d, hr_q, hr_d, wl_q, wl_d, wr_q, wr_d;
  logic              ljp_q, ljp_d, frm_q, frm_d, dat_q, dat_d;
  logic              fall, last, boundary, accept;
  logic              lj_bit, rj_bit, dsd_l, dsd_r, pcm_bit;

  audser_clkgen #(
    .PCM_HALF(PCM_HALF), .DSD64_HALF(DSD64_HALF), .DSD128_HALF(DSD128_HALF)
  ) u_clkgen (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg_q), .bclk_o(bclk_o), .fall_o(fall)
  );

  // frame position / sample load / configuration next state
  always_comb begin
    cfg_in   = '{dsd: dsd_mode_i, dsd_fast: dsd_fast_i,
                 fmt: fmt_decode(fmt_sel_i), wsel: width_sel_i};
    last     = cfg_q.dsd ? (pos_q == DSD_LAST) : (pos_q == PCM_LAST);
    boundary = fall & last;
    accept   = smp_valid_i & ~full_q;
    cfg_d    = cfg_q;
    pos_d    = pos_q;
    mute_d   = mute_q;
    wl_d     = wl_q;
    wr_d     = wr_q;
    hl_d     = accept ? smp_left_i  : hl_q;
    hr_d     = accept ? smp_right_i : hr_q;
    full_d   = (full_q & ~boundary) | accept;
    if (boundary) begin
      cfg_d  = cfg_in;
      mute_d = (cfg_in != cfg_q);
      wl_d   = full_q ? hl_q : '0;
      wr_d   = full_q ? hr_q : '0;
      pos_d  = '0;
    end else if (fall) begin
      pos_d  = pos_q + 1'b1;
    end
  end

  audser_bitsel u_bitsel (
    .cfg_i(cfg_d), .left_i(wl_d), .right_i(wr_d), .pos_i(pos_d),
    .lj_o(lj_bit), .rj_o(rj_bit), .dsd_l_o(dsd_l), .dsd_r_o(dsd_r)
  );

  // pin values for the slot that starts at this falling edge
  always_comb begin
    case (cfg_d.fmt)
      FMT_LEFT:  pcm_bit = lj_bit;
      FMT_RIGHT: pcm_bit = rj_bit;
      default:   pcm_bit = ljp_q;
    endcase
    frm_d = frm_q;
    dat_d = dat_q;
    ljp_d = ljp_q;
    if (fall) begin
      ljp_d = lj_bit;
      if (cfg_d.dsd) begin
        frm_d = dsd_l & ~mute_d;
        dat_d = dsd_r & ~mute_d;
      end else begin
        frm_d = pos_d[POS_W-1];
        dat_d = pcm_bit & ~mute_d;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '{dsd: 1'b0, dsd_fast: 1'b0, fmt: FMT_DELAY, wsel: 2'b00};
      pos_q  <= PCM_LAST;
      mute_q <= 1'b0;
      full_q <= 1'b0;
      hl_q   <= '0;
      hr_q   <= '0;
      wl_q   <= '0;
      wr_q   <= '0;
      ljp_q  <= 1'b0;
      frm_q  <= 1'b0;
      dat_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      pos_q  <= pos_d;
      mute_q <= mute_d;
      full_q <= full_d;
      hl_q   <= hl_d;
      hr_q   <= hr_d;
      wl_q   <= wl_d;
      wr_q   <= wr_d;
      ljp_q  <= ljp_d;
      frm_q  <= frm_d;
      dat_q  <= dat_d;
    end
  end

  assign smp_ready_o = ~full_q;
  assign frm_o       = frm_q;
  assign dat_o       = dat_q;

endmodule

// File: rtl/audser_chk.sv
module audser_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bclk_o,
  input logic       frm_o,
  input logic       dat_o,
  input logic       smp_ready_o,
  input logic [5:0] cfg_bits
);

  AST_DAT_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(dat_o) |-> $fell(bclk_o)); // R2

  AST_FRM_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(frm_o) |-> $fell(bclk_o)); // R3

  AST_READY_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(smp_ready_o) |-> $fell(bclk_o)); // R9

  AST_SILENT_AFTER_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_bits != $past(cfg_bits)) |-> !dat_o); // R11

endmodule

bind audio_serial_tx audser_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bclk_o(bclk_o), .frm_o(frm_o),
  .dat_o(dat_o), .smp_ready_o(smp_ready_o), .cfg_bits(cfg_q)
);

// File: tb/audio_serial_tx_tb.sv
`timescale 1ns/1ps
module audio_serial_tx_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        smp_valid_i;
  logic        smp_ready_o;
  logic [31:0] smp_left_i, smp_right_i;
  logic        dsd_mode_i, dsd_fast_i;
  logic [1:0]  fmt_sel_i, width_sel_i;
  logic        bclk_o, frm_o, dat_o;

  int n_chk = 0;
  int n_bad = 0;

  audio_serial_tx u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i),
    .smp_ready_o(smp_ready_o), .smp_left_i(smp_left_i), .smp_right_i(smp_right_i),
    .dsd_mode_i(dsd_mode_i), .dsd_fast_i(dsd_fast_i), .fmt_sel_i(fmt_sel_i),
    .width_sel_i(width_sel_i), .bclk_o(bclk_o), .frm_o(frm_o), .dat_o(dat_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_pcm(input logic [1:0] f, input logic [1:0] w,
                                          input logic [31:0] l, input logic [31:0] r,
                                          input logic prev);
    int          wd;
    logic [31:0] m, sl, sr;
    logic [63:0] fr;
    wd = (w == 2'b00) ? 16 : (w == 2'b01) ? 24 : 32;
    m  = (wd == 32) ? 32'hFFFF_FFFF : ((32'd1 << wd) - 32'd1);
    if (f == 2'b10) begin
      sl = l & m;
      sr = r & m;
    end else begin
      sl = (l & m) << (32 - wd);
      sr = (r & m) << (32 - wd);
    end
    fr = {sl, sr};
    if (f == 2'b01 || f == 2'b10) return fr;
    return {prev, fr[63:1]};
  endfunction

  task automatic push(input logic [31:0] l, input logic [31:0] r);
    @(negedge clk_i);
    while (!smp_ready_o) @(negedge clk_i);
    smp_valid_i = 1'b1;
    smp_left_i  = l;
    smp_right_i = r;
    @(negedge clk_i);
    smp_valid_i = 1'b0;
    check("R9", "ready low while holding", {63'd0, smp_ready_o}, 64'd0);
  endtask

  task automatic cap_pcm(output logic [63:0] d, output logic [63:0] fr);
    @(negedge frm_o);
    for (int i = 0; i < 64; i++) begin
      @(posedge bclk_o);
      d[63-i]  = dat_o;
      fr[63-i] = frm_o;
    end
  endtask

  task automatic run(input logic [31:0] l, input logic [31:0] r,
                     output logic [63:0] d, output logic [63:0] fr);
    @(negedge frm_o);
    push(l, r);
    cap_pcm(d, fr);
  endtask

  task automatic configure(input logic [1:0] f, input logic [1:0] w);
    @(negedge frm_o);
    fmt_sel_i   = f;
    width_sel_i = w;
    @(negedge frm_o);
  endtask

  task automatic period(output int p);
    realtime t0;
    @(posedge bclk_o);
    t0 = $realtime;
    @(posedge bclk_o);
    p = int'(($realtime - t0) / 20.0);
  endtask

  task automatic t_reset;
    check("R1", "bclk in reset", {63'd0, bclk_o}, 64'd0);
    check("R1", "frm in reset", {63'd0, frm_o}, 64'd0);
    check("R1", "dat in reset", {63'd0, dat_o}, 64'd0);
    check("R1", "ready in reset", {63'd0, smp_ready_o}, 64'd1);
  endtask

  task automatic t_delay16;
    logic [63:0] d, fr;
    int p;
    period(p);
    check("R3", "pcm bclk period", 64'(p), 64'd4);
    run(32'hDEAD_A5C3, 32'h0000_1234, d, fr);
    check("R3", "frame pin halves", fr, {32'h0, 32'hFFFF_FFFF});
    check("R4", "delayed framing 16b", d, exp_pcm(2'b00, 2'b00, 32'hA5C3, 32'h1234, 1'b0));
    cap_pcm(d, fr);
    check("R9", "no pending pair gives zeros", d, 64'd0);
  endtask

  task automatic t_left24;
    logic [63:0] d, fr;
    configure(2'b01, 2'b01);
    run(32'h77AB_CDEF, 32'h1112_3456, d, fr);
    check("R5", "left-aligned 24b", d, exp_pcm(2'b01, 2'b01, 32'hAB_CDEF, 32'h12_3456, 1'b0));
    check("R8", "upper bits ignored 24b", d, {32'hABCDEF00, 32'h12345600});
  endtask

  task automatic t_right16;
    logic [63:0] d, fr;
    configure(2'b10, 2'b00);
    run(32'hFFFF_8001, 32'h0000_00FF, d, fr);
    check("R6", "right-aligned 16b", d, {32'h0000_8001, 32'h0000_00FF});
  endtask

  task automatic t_both_bits;
    logic [63:0] d, fr;
    configure(2'b11, 2'b00);
    run(32'h0000_F00D, 32'h0000_0BEE, d, fr);
    check("R7", "fmt 11 acts as delayed", d, exp_pcm(2'b00, 2'b00, 32'hF00D, 32'h0BEE, 1'b0));
  endtask

  task automatic t_delay32;
    logic [63:0] d, fr;
    configure(2'b00, 2'b10);
    run(32'h8000_0001, 32'hC0FF_EE01, d, fr);
    check("R8", "delayed 32b slots 1..63", {1'b0, d[62:0]},
          {1'b0, exp_pcm(2'b00, 2'b10, 32'h8000_0001, 32'hC0FF_EE01, 1'b0)} & 64'h7FFF_FFFF_FFFF_FFFF);
    cap_pcm(d, fr);
    check("R4", "right LSB spills into next slot 0", d, {1'b1, 63'd0});
  endtask

  task automatic t_switch_mute;
    logic [63:0] d, fr;
    @(negedge frm_o);
    fmt_sel_i   = 2'b01;
    width_sel_i = 2'b00;
    push(32'h0000_FFFF, 32'h0000_FFFF);
    cap_pcm(d, fr);
    check("R11", "first frame after change silent", d, 64'd0);
    run(32'h0000_FFFF, 32'h0000_8001, d, fr);
    check("R11", "next frame uses new framing", d, {32'hFFFF_0000, 32'h8001_0000});
  endtask

  task automatic t_dsd;
    logic [31:0] dl, dr;
    int p, guard;
    @(negedge frm_o);
    dsd_mode_i = 1'b1;
    dsd_fast_i = 1'b0;
    push(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    repeat (300) @(posedge clk_i);
    push(32'hA5A5_0F0F, 32'hC3C3_1234);
    guard = 0;
    do begin
      @(posedge bclk_o);
      guard++;
    end while (frm_o !== 1'b1 && guard < 200);
    dl[31] = frm_o;
    dr[31] = dat_o;
    for (int i = 30; i >= 0; i--) begin
      @(posedge bclk_o);
      dl[i] = frm_o;
      dr[i] = dat_o;
    end
    check("R10", "dsd left stream", 64'(dl), 64'hA5A5_0F0F);
    check("R10", "dsd right stream", 64'(dr), 64'hC3C3_1234);
    period(p);
    check("R10", "dsd base clock period", 64'(p), 64'd8);
    dsd_fast_i = 1'b1;
    repeat (600) @(posedge clk_i);
    period(p);
    check("R10", "dsd doubled clock period", 64'(p), 64'd4);
  endtask

  task automatic report;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20.0 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  initial begin
    rst_ni      = 1'b0;
    smp_valid_i = 1'b0;
    smp_left_i  = '0;
    smp_right_i = '0;
    dsd_mode_i  = 1'b0;
    dsd_fast_i  = 1'b0;
    fmt_sel_i   = 2'b00;
    width_sel_i = 2'b00;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_delay16();
    t_left24();
    t_right16();
    t_both_bits();
    t_delay32();
    t_switch_mute();
    t_dsd();
    report();
  end

endmodule